// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block produces every refresh operation a single-bit asynchronous DRAM needs. Out of reset it waits out a power-up pause and then runs a warm-up burst of refresh cycles. Only after that burst does it tell the access controller that host traffic may begin. From then on an interval timer asks for one refresh per period. Each refresh is taken by a request/grant handshake with the access controller. While it owns the bus, the block drives its own copies of the row strobe, column strobe and write enable. An external multiplexer selects these copies for the pins whenever `own_bus` is high. Every refresh uses column-first ordering, so the DRAM's internal row counter picks the row and no address is driven.

If a grant is late, the intervals that pass are recorded as owed refreshes, up to a cap. All owed refreshes are then run back to back under one grant. A host may also request self-refresh. The block first runs one ordinary refresh and then holds the strobes in the self-refresh condition for at least a minimum time. On exit it observes a long precharge and runs a second ordinary refresh before it releases the bus.

The controller has eight states:
- PWRUP: the power-up pause.
- IDLE: waiting for work.
- REQ: request raised, waiting for the grant.
- CAS_LEAD: column strobe low, row strobe still high.
- RAS_LOW: both strobes low.
- PRECH: both strobes high.
- SELF_HOLD: both strobes held low for self-refresh.
- SELF_EXIT: long precharge after self-refresh.

The transitions are:
- PWRUP→IDLE: when the pause ends. The owed count is loaded with the warm-up size.
- IDLE→REQ: when a refresh is owed. If nothing is owed and self-refresh is requested after initialisation, the block goes to REQ in the entry phase.
- REQ→CAS_LEAD: on grant.
- CAS_LEAD→RAS_LOW: in normal phases. In the hold phase the block goes to SELF_HOLD instead.
- RAS_LOW→PRECH: after the low time.
- PRECH→CAS_LEAD: when more refreshes are owed, or after the entry refresh.
- PRECH→IDLE: otherwise.
- SELF_HOLD→SELF_EXIT: once the minimum hold time has passed and the self-refresh request is low.
- SELF_EXIT→CAS_LEAD: in the return phase, which runs the closing refresh.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1 and `own_bus`, `ref_req`, `init_done` and `self_active` are 0.
- R2: The first `ref_req` goes high exactly PWRUP_CYC+1 clock cycles after reset is released, and `ref_req` stays low before that.
- R3: After the pause, exactly INIT_CNT refresh cycles run back to back under a single request/grant. `init_done` goes to 1 as the bus is released after the last of them and stays 1. `self_req` has no effect while `init_done` is 0.
- R4: In every refresh, `cas_n` falls CAS_LEAD_CYC cycles before `ras_n` falls and stays 0 for as long as `ras_n` is 0. `we_n` is 1 whenever `own_bus` is 1.
- R5: In an ordinary refresh, `ras_n` is 0 for exactly RAS_LOW_CYC cycles. Between two row-strobe low pulses in one ownership window, `ras_n` is 1 for PRECH_CYC+CAS_LEAD_CYC cycles, never less than PRECH_CYC.
- R6: After `init_done`, the interval timer fires every INTERVAL_CYC cycles. When grants are immediate, consecutive rising edges of `ref_req` are exactly INTERVAL_CYC cycles apart, and each one leads to a single refresh.
- R7: `ref_req` stays 1 until `ref_gnt` is seen, and `own_bus` rises only in the cycle after `ref_req` and `ref_gnt` are both 1. `ras_n` and `cas_n` are 0 only while `own_bus` is 1.
- R8: Each interval that ends while a refresh is still outstanding adds one to an owed count. The count saturates at OWED_MAX. On grant, all owed refreshes run back to back in one ownership window; for example, two intervals missed beyond the pending one give 3 refreshes, and twelve missed intervals give OWED_MAX.
- R9: Self-refresh starts when `self_req` is 1, `init_done` is 1 and nothing is owed. The ownership window then holds an ordinary refresh, the self-refresh pulse and a closing ordinary refresh, which makes three row-strobe low pulses. `self_active` is 1 exactly while the strobes are held.
- R10: During self-refresh, `ras_n` stays 0 for at least SELF_MIN_CYC cycles, and for as long after that as `self_req` stays 1.
- R11: On leaving self-refresh, `ras_n` is 1 for exactly SELF_EXIT_CYC+CAS_LEAD_CYC cycles before the closing refresh pulls it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_req | input | 1 | Level request to enter and remain in self-refresh |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| init_done | output | 1 | Warm-up complete; host accesses may start |
| own_bus | output | 1 | Select for the pin multiplexer: the strobes below drive the DRAM |
| ras_n | output | 1 | Row strobe copy, active low |
| cas_n | output | 1 | Column strobe copy, active low |
| we_n | output | 1 | Write enable copy, held high |
| self_active | output | 1 | DRAM is being held in self-refresh |

## Verification
The hardest case to reach is the owed-count ceiling. Enough intervals must pass without a grant, and the grant must then arrive at a point where no new interval can expire during the catch-up burst. The bench withholds the grant, notes the cycle of the pending request's rise, and counts whole intervals from there. It grants a few cycles after a known timer expiry, so the burst length can be predicted exactly: 3 refreshes in one case and the cap in the other. Self-refresh is driven the same way, from a point just after a completed refresh, with both a short request that is stretched to the minimum and a long request that sets the pulse length itself.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_REQ,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECH,
        ST_SELF_HOLD,
        ST_SELF_EXIT
    } ref_state_e;

    // Which kind of refresh sequence the strobes are in
    typedef enum logic [1:0] {
        PH_NORM,    // distributed / warm-up / owed refresh
        PH_ENTRY,   // ordinary refresh before self-refresh
        PH_HOLD,    // column strobe lead that opens the self-refresh pulse
        PH_RETURN   // ordinary refresh after self-refresh
    } ref_phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R6: one expiry per interval, never two in a row
    p_tick_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/cbr_owed_ledger.sv
module cbr_owed_ledger #(
    parameter int unsigned OWED_MAX = 8,
    parameter int unsigned INIT_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_init,
    input  logic add,
    input  logic pay,
    output logic any_owed
);
    localparam int unsigned OW = $clog2(OWED_MAX + 1);
    localparam logic [OW-1:0] CAP  = OW'(OWED_MAX);
    localparam logic [OW-1:0] WARM = OW'(INIT_CNT);

    logic [OW-1:0] owed_q, owed_d;

    always_comb begin
        owed_d = owed_q;
        if (load_init) begin
            owed_d = WARM;
        end else if (add && !pay) begin
            if (owed_q != CAP) owed_d = owed_q + 1'b1;
        end else if (pay && !add) begin
            owed_d = owed_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    assign any_owed = (owed_q != '0);

    // R8: the owed count never exceeds its cap
    p_owed_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CAP);

    // R8: a refresh is only paid off when one is owed
    p_pay_needs_debt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pay |-> any_owed);

endmodule

// File: rtl/cbr_phase_timer.sv
module cbr_phase_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          reached
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q >= limit);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned PWRUP_CYC     = 20000,
    parameter int unsigned INIT_CNT      = 8,
    parameter int unsigned INTERVAL_CYC  = 1560,
    parameter int unsigned OWED_MAX      = 8,
    parameter int unsigned CAS_LEAD_CYC  = 1,
    parameter int unsigned RAS_LOW_CYC   = 5,
    parameter int unsigned PRECH_CYC     = 3,
    parameter int unsigned SELF_MIN_CYC  = 10000,
    parameter int unsigned SELF_EXIT_CYC = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic self_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic init_done,
    output logic own_bus,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic self_active
);
    localparam int unsigned MAXD = max_u(max_u(PWRUP_CYC, SELF_MIN_CYC),
                                   max_u(max_u(SELF_EXIT_CYC, RAS_LOW_CYC),
                                         max_u(PRECH_CYC, CAS_LEAD_CYC)));
    localparam int unsigned CW = $clog2(MAXD + 1);

    ref_state_e state_q, state_d;
    ref_phase_e phase_q, phase_d;
    logic       init_q;
    logic [CW-1:0] limit;
    logic       reached, restart;
    logic       any_owed, tick, pay, load_init, timer_run;

    // ---------------- sub-blocks ----------------
    assign timer_run = init_q && (phase_q == PH_NORM);

    cbr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    cbr_owed_ledger #(.OWED_MAX(OWED_MAX), .INIT_CNT(INIT_CNT)) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (load_init),
        .add       (tick),
        .pay       (pay),
        .any_owed  (any_owed)
    );

    assign restart = (state_d != state_q);

    cbr_phase_timer #(.CW(CW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .reached (reached)
    );

    // ---------------- per-state duration ----------------
    always_comb begin
        unique case (state_q)
            ST_PWRUP:     limit = CW'(PWRUP_CYC - 1);
            ST_CAS_LEAD:  limit = CW'(CAS_LEAD_CYC - 1);
            ST_RAS_LOW:   limit = CW'(RAS_LOW_CYC - 1);
            ST_PRECH:     limit = CW'(PRECH_CYC - 1);
            ST_SELF_HOLD: limit = CW'(SELF_MIN_CYC - 1);
            ST_SELF_EXIT: limit = CW'(SELF_EXIT_CYC - 1);
            default:      limit = '0;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d   = state_q;
        phase_d   = phase_q;
        load_init = 1'b0;
        pay       = 1'b0;
        unique case (state_q)
            ST_PWRUP: begin
                if (reached) begin
                    state_d   = ST_IDLE;
                    load_init = 1'b1;
                end
            end
            ST_IDLE: begin
                if (any_owed) begin
                    state_d = ST_REQ;
                    phase_d = PH_NORM;
                end else if (self_req && init_q) begin
                    state_d = ST_REQ;
                    phase_d = PH_ENTRY;
                end
            end
            ST_REQ: begin
                if (ref_gnt) state_d = ST_CAS_LEAD;
            end
            ST_CAS_LEAD: begin
                if (reached) begin
                    state_d = (phase_q == PH_HOLD) ? ST_SELF_HOLD : ST_RAS_LOW;
                end
            end
            ST_RAS_LOW: begin
                if (reached) begin
                    state_d = ST_PRECH;
                    pay     = (phase_q == PH_NORM);
                end
            end
            ST_PRECH: begin
                if (reached) begin
                    unique case (phase_q)
                        PH_ENTRY: begin
                            state_d = ST_CAS_LEAD;
                            phase_d = PH_HOLD;
                        end
                        PH_RETURN: begin
                            state_d = ST_IDLE;
                            phase_d = PH_NORM;
                        end
                        default: begin
                            state_d = any_owed ? ST_CAS_LEAD : ST_IDLE;
                        end
                    endcase
                end
            end
            ST_SELF_HOLD: begin
                if (reached && !self_req) state_d = ST_SELF_EXIT;
            end
            ST_SELF_EXIT: begin
                if (reached) begin
                    state_d = ST_CAS_LEAD;
                    phase_d = PH_RETURN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            phase_q <= PH_NORM;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (state_q == ST_PRECH && state_d == ST_IDLE) init_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ref_req     = 1'b0;
        own_bus     = 1'b0;
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        self_active = 1'b0;
        unique case (state_q)
            ST_REQ:       ref_req = 1'b1;
            ST_CAS_LEAD:  begin own_bus = 1'b1; cas_n = 1'b0; end
            ST_RAS_LOW:   begin own_bus = 1'b1; cas_n = 1'b0; ras_n = 1'b0; end
            ST_PRECH:     own_bus = 1'b1;
            ST_SELF_HOLD: begin own_bus = 1'b1; cas_n = 1'b0; ras_n = 1'b0;
                                self_active = 1'b1; end
            ST_SELF_EXIT: own_bus = 1'b1;
            default: ;
        endcase
    end

    assign we_n      = 1'b1;
    assign init_done = init_q;

    // ---------------- timing checks ----------------
    logic [CW-1:0] ras_low_len, ras_high_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_low_len  <= '0;
            ras_high_len <= '0;
        end else begin
            if (ras_n) begin
                ras_low_len <= '0;
                if (ras_high_len != {CW{1'b1}}) ras_high_len <= ras_high_len + 1'b1;
            end else begin
                ras_high_len <= '0;
                if (ras_low_len != {CW{1'b1}}) ras_low_len <= ras_low_len + 1'b1;
            end
        end
    end

    // R4: column strobe is already low when the row strobe falls
    p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R4: column strobe stays low for the whole row-strobe low time
    p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5: minimum row-strobe low width
    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_low_len >= CW'(RAS_LOW_CYC)));

    // R5: minimum precharge before the next row-strobe fall
    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_high_len >= CW'(PRECH_CYC)));

    // R10: self-refresh pulse is at least the minimum hold time
    p_self_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && $past(self_active)) |-> (ras_low_len >= CW'(SELF_MIN_CYC)));

    // R7: a request is only withdrawn after a grant
    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> $past(ref_gnt));

    // R7: bus ownership only follows a granted request
    p_own_after_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_bus) |-> $past(ref_req && ref_gnt));

    // R7: strobes are only active while the bus is owned
    p_strobe_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> own_bus);

    // R3: once set, the initialisation flag stays set
    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done);

endmodule

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;

    localparam int PWRUP   = 40;
    localparam int INIT    = 8;
    localparam int IVL     = 200;
    localparam int OWMAX   = 8;
    localparam int LEAD    = 1;
    localparam int RLOW    = 5;
    localparam int PRE     = 3;
    localparam int SMIN    = 30;
    localparam int SEXIT   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic self_req = 1'b0;
    logic gnt_en = 1'b1;
    logic ref_gnt, ref_req, init_done, own_bus, ras_n, cas_n, we_n, self_active;

    assign ref_gnt = gnt_en && ref_req;

    always #5 clk = ~clk;

    cbr_refresh_sched #(
        .PWRUP_CYC(PWRUP), .INIT_CNT(INIT), .INTERVAL_CYC(IVL), .OWED_MAX(OWMAX),
        .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(RLOW), .PRECH_CYC(PRE),
        .SELF_MIN_CYC(SMIN), .SELF_EXIT_CYC(SEXIT)
    ) u_cbr_refresh_sched (
        .clk(clk), .rst_n(rst_n), .self_req(self_req), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .init_done(init_done), .own_bus(own_bus),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .self_active(self_active)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // ---------------- monitor ----------------
    logic ras_p, cas_p, own_p;
    int low_len, high_len, win_falls, last_win, self_len, post_self_high;
    bit pulse_self, after_self;
    int bad_lead, bad_hold, bad_we, bad_width, bad_prech, bad_own, bad_early;

    initial begin
        bad_lead = 0; bad_hold = 0; bad_we = 0; bad_width = 0;
        bad_prech = 0; bad_own = 0; bad_early = 0;
        last_win = 0; self_len = 0; post_self_high = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            ras_p = 1'b1; cas_p = 1'b1; own_p = 1'b0;
            low_len = 0; high_len = 0; win_falls = 0;
            pulse_self = 0; after_self = 0;
        end else begin
            if (own_bus && !we_n) bad_we++;
            if (!ras_n && cas_n) bad_hold++;
            if ((!ras_n || !cas_n) && !own_bus) bad_own++;
            if (self_active && !init_done) bad_early++;
            if (own_bus && !own_p) win_falls = 0;
            if (ras_p && !ras_n) begin
                if (cas_p) bad_lead++;
                if (after_self) begin
                    post_self_high = high_len;
                    after_self = 0;
                end else if (win_falls > 0 && high_len != PRE + LEAD) begin
                    bad_prech++;
                end
                win_falls++;
                high_len = 0;
            end
            if (!ras_p && ras_n) begin
                if (pulse_self) begin
                    self_len = low_len;
                    after_self = 1;
                end else if (low_len != RLOW) begin
                    bad_width++;
                end
                low_len = 0;
                pulse_self = 0;
            end
            if (!ras_n) begin
                low_len++;
                if (self_active) pulse_self = 1;
            end else begin
                high_len++;
            end
            if (!own_bus && own_p) last_win = win_falls;
            ras_p = ras_n; cas_p = cas_n; own_p = own_bus;
        end
    end

    // ---------------- helpers ----------------
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req_rise(output int c);
        while (ref_req) step();
        while (!ref_req) step();
        c = cyc;
    endtask

    task automatic wait_window_end();
        while (!own_bus) step();
        while (own_bus) step();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c0, c1, c2, c, n;
        rst_n = 1'b0;
        repeat (3) step();
        // R1 reset state
        check(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
        check(cas_n == 1'b1, "R1 cas_n", cas_n, 1);
        check(we_n == 1'b1, "R1 we_n", we_n, 1);
        check(own_bus == 1'b0 && ref_req == 1'b0, "R1 own_bus/ref_req", own_bus + ref_req, 0);
        check(init_done == 1'b0 && self_active == 1'b0, "R1 init_done/self_active",
              init_done + self_active, 0);
        rst_n = 1'b1;

        // R2 power-up pause
        while (!ref_req) step();
        check(cyc == PWRUP + 1, "R2 first request cycle", cyc, PWRUP + 1);

        // R3 warm-up burst
        while (!init_done) step();
        check(last_win == INIT, "R3 warm-up refresh count", last_win, INIT);
        c = 0;
        repeat (5) begin step(); if (!init_done) c++; end
        check(c == 0, "R3 init_done stays high", c, 0);

        // R6 interval spacing
        wait_req_rise(c0);
        wait_window_end();
        check(last_win == 1, "R6 single refresh per interval", last_win, 1);
        wait_req_rise(c1);
        wait_req_rise(c2);
        check(c1 - c0 == IVL, "R6 spacing a", c1 - c0, IVL);
        check(c2 - c1 == IVL, "R6 spacing b", c2 - c1, IVL);
        wait_window_end();

        // R8 owed refreshes, unsaturated
        gnt_en = 1'b0;
        wait_req_rise(c);
        while (cyc < c + 2 * IVL + 10) step();
        check(ref_req == 1'b1 && own_bus == 1'b0, "R7 request held until grant",
              ref_req, 1);
        gnt_en = 1'b1;
        wait_window_end();
        check(last_win == 3, "R8 owed burst of three", last_win, 3);

        // R8 owed refreshes, saturated
        gnt_en = 1'b0;
        wait_req_rise(c);
        while (cyc < c + 11 * IVL + 10) step();
        gnt_en = 1'b1;
        wait_window_end();
        check(last_win == OWMAX, "R8 owed burst saturates", last_win, OWMAX);

        // R9 R10 R11 self-refresh, short request
        wait_req_rise(c);
        wait_window_end();
        self_req = 1'b1;
        while (!self_active) step();
        repeat (5) step();
        self_req = 1'b0;
        wait_window_end();
        check(self_len == SMIN, "R10 short request stretched to minimum", self_len, SMIN);
        check(last_win == 3, "R9 bracketed self window pulses", last_win, 3);
        check(post_self_high == SEXIT + LEAD, "R11 exit precharge", post_self_high, SEXIT + LEAD);

        // R10 self-refresh, long request
        wait_req_rise(c);
        wait_window_end();
        self_req = 1'b1;
        while (!self_active) step();
        n = 1;
        while (n < 60) begin
            step();
            if (self_active) n++;
        end
        self_req = 1'b0;
        wait_window_end();
        check(self_len == 60, "R10 long request length", self_len, 60);
        check(post_self_high == SEXIT + LEAD, "R11 exit precharge long", post_self_high,
              SEXIT + LEAD);

        // R3 self request during warm-up is ignored
        rst_n = 1'b0;
        self_req = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        while (!init_done) step();
        check(last_win == INIT, "R3 warm-up count with self_req high", last_win, INIT);
        check(bad_early == 0, "R3 no self-refresh before init_done", bad_early, 0);
        while (!self_active) step();
        self_req = 1'b0;
        wait_window_end();
        check(last_win == 3, "R9 self window after init", last_win, 3);

        // protocol monitors
        check(bad_lead == 0, "R4 CAS low before RAS falls", bad_lead, 0);
        check(bad_hold == 0, "R4 CAS held while RAS low", bad_hold, 0);
        check(bad_we == 0, "R4 W high while owned", bad_we, 0);
        check(bad_width == 0, "R5 RAS low width", bad_width, 0);
        check(bad_prech == 0, "R5 precharge between pulses", bad_prech, 0);
        check(bad_own == 0, "R7 strobes only when owned", bad_own, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule